// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level page table kept in memory. A caller hands it a virtual address together with the physical address of the top-level table. The walker then makes two dependent reads through a single valid/ready memory read port. The first read fetches a top-level entry, which names a second-level table. The second read fetches the leaf entry, which names the 4 KB frame. The walker reports the physical address and the combined access rights. If either entry is marked not valid, it reports a page fault and says which level caused it.

Each table holds 1024 word-sized entries, so one table fills exactly one 4 KB page. The walker handles one translation at a time. It takes a new request only while it is idle. Each finished walk produces a single-cycle result strobe. A translation cache in front of it, and any fault handling after it, belong to the surrounding system.

Top module: `pt_walker`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1 and both `mem_req_valid` and `done_valid` are 0.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both 1. While a walk is in progress, `req_ready` is 0 and `req_valid` has no effect on the walk or its result.
- R3: The first memory read goes to byte address {base[31:12], va[31:22], 2'b00}. Bits 11:0 of the base input are ignored.
- R4: The second read goes to {E1[31:12], va[21:12], 2'b00}, where E1 is the top-level entry. It is issued only after the first response has arrived.
- R5: A memory request, once raised, stays raised with an unchanged address until `mem_req_ready` is seen high.
- R6: On a successful walk, `done_paddr` = {E2[31:12], va[11:0]}, where E2 is the leaf entry. The page offset passes through unchanged.
- R7: In an entry, bit 0 is valid, bit 1 is read, bit 2 is write and bit 3 is execute. On success, `done_rights` (bit 0 read, bit 1 write, bit 2 execute) is the bitwise AND of E1[3:1] and E2[3:1].
- R8: If E1 bit 0 is 0, the walk ends after one read with `done_fault`=1, `done_fault_lvl`=0, `done_paddr`=0 and `done_rights`=0.
- R9: If E2 bit 0 is 0, the walk ends with `done_fault`=1, `done_fault_lvl`=1, `done_paddr`=0 and `done_rights`=0.
- R10: `done_valid` is high for exactly one cycle per walk, and `req_ready` is 1 in the following cycle.
- R11: Entry bits 11:4 do not affect addresses, rights or fault status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_base | input | 32 | Physical address of the top-level table (bits 31:12 used) |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Entry read from memory |
| done_valid | output | 1 | One-cycle result strobe |
| done_paddr | output | 32 | Translated physical address (0 on fault) |
| done_rights | output | 3 | Combined rights: read, write, execute (0 on fault) |
| done_fault | output | 1 | Page fault |
| done_fault_lvl | output | 1 | Level that faulted: 0 top-level, 1 second-level |

## Verification
The assertions watch every cycle for four things:

- the memory request staying stable while it is stalled;
- a single-cycle result strobe that returns the walker to idle;
- the idle state staying quiet on both the memory port and the result port;
- a faulted result being zeroed, with the page offset passed through on success.

Only the bench scenarios can show the rest:

- that the two read addresses are formed from the right index fields and the right frames;
- that rights are combined across both levels;
- that the fault level is reported correctly;
- that junk entry bits and requests made while busy are ignored.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_L1_REQ  = 3'd1,
    ST_L1_WAIT = 3'd2,
    ST_L2_REQ  = 3'd3,
    ST_L2_WAIT = 3'd4,
    ST_DONE    = 3'd5
  } walk_st_e;

  typedef enum logic {
    LVL_TOP  = 1'b0,
    LVL_LEAF = 1'b1
  } walk_lvl_e;

endpackage

// File: rtl/pt_walk_pte_dec.sv
module pt_walk_pte_dec #(
  parameter int PTE_W    = 32,
  parameter int OFF_W    = 12,
  parameter int RIGHTS_W = 3
) (
  input  logic [PTE_W-1:0]       pte,
  output logic                   pte_ok,
  output logic [RIGHTS_W-1:0]    pte_rights,
  output logic [PTE_W-OFF_W-1:0] pte_frame
);
  // Bit 0 valid, bits RIGHTS_W:1 rights, top bits frame; the rest ignored.
  always_comb begin
    pte_ok     = pte[0];
    pte_rights = pte[RIGHTS_W:1];
    pte_frame  = pte[PTE_W-1:OFF_W];
  end
endmodule

// File: rtl/pt_walk_addr_gen.sv
module pt_walk_addr_gen #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  parameter int LEVELS = 2
) (
  input  logic [VA_W-1:0]        va,
  input  logic [PA_W-OFF_W-1:0]  root_frame,
  input  logic [PA_W-OFF_W-1:0]  next_frame,
  input  logic                   leaf_sel,
  output logic [PA_W-1:0]        addr
);
  localparam int ENT_LOG2 = OFF_W - IDX_W;

  logic [IDX_W-1:0] idx [LEVELS];

  // Level 0 takes the highest index field, the last level the lowest.
  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_idx
    assign idx[lv] = va[OFF_W + (LEVELS-1-lv)*IDX_W +: IDX_W];
  end

  always_comb begin
    if (leaf_sel) addr = {next_frame, idx[LEVELS-1], {ENT_LOG2{1'b0}}};
    else          addr = {root_frame, idx[0],        {ENT_LOG2{1'b0}}};
  end
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     req_valid,
  input  logic     mem_req_ready,
  input  logic     mem_rsp_valid,
  input  logic     pte_ok,
  output walk_st_e st,
  output logic     accept,
  output logic     top_take,
  output logic     leaf_take
);
  walk_st_e st_nx;

  always_comb begin
    accept    = (st == ST_IDLE) && req_valid;
    top_take  = (st == ST_L1_WAIT) && mem_rsp_valid;
    leaf_take = (st == ST_L2_WAIT) && mem_rsp_valid;
    st_nx     = st;
    unique case (st)
      ST_IDLE:    if (req_valid)     st_nx = ST_L1_REQ;
      ST_L1_REQ:  if (mem_req_ready) st_nx = ST_L1_WAIT;
      ST_L1_WAIT: if (mem_rsp_valid) st_nx = pte_ok ? ST_L2_REQ : ST_DONE;
      ST_L2_REQ:  if (mem_req_ready) st_nx = ST_L2_WAIT;
      ST_L2_WAIT: if (mem_rsp_valid) st_nx = ST_DONE;
      ST_DONE:                       st_nx = ST_IDLE;
      default:                       st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nx;
  end

  AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DONE) |=> (st == ST_IDLE)); // R10
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int PTE_W    = 32,
  parameter int OFF_W    = 12,
  parameter int IDX_W    = 10,
  parameter int RIGHTS_W = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [VA_W-1:0]     req_vaddr,
  input  logic [PA_W-1:0]     req_base,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [PA_W-1:0]     mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [PTE_W-1:0]    mem_rsp_data,
  output logic                done_valid,
  output logic [PA_W-1:0]     done_paddr,
  output logic [RIGHTS_W-1:0] done_rights,
  output logic                done_fault,
  output logic                done_fault_lvl
);
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int LEVELS  = 2;

  walk_st_e              st;
  logic                  accept, top_take, leaf_take;
  logic                  pte_ok;
  logic [RIGHTS_W-1:0]   pte_rights;
  logic [PTE_W-OFF_W-1:0] pte_frame;

  logic [VA_W-1:0]       va_q;
  logic [FRAME_W-1:0]    root_q, next_q;
  logic [RIGHTS_W-1:0]   rights_q;
  logic [PA_W-1:0]       paddr_q;
  logic                  fault_q;
  walk_lvl_e             flvl_q;

  pt_walk_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .pte_ok        (pte_ok),
    .st            (st),
    .accept        (accept),
    .top_take      (top_take),
    .leaf_take     (leaf_take)
  );

  pt_walk_pte_dec #(.PTE_W(PTE_W), .OFF_W(OFF_W), .RIGHTS_W(RIGHTS_W)) u_dec (
    .pte        (mem_rsp_data),
    .pte_ok     (pte_ok),
    .pte_rights (pte_rights),
    .pte_frame  (pte_frame)
  );

  pt_walk_addr_gen #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W),
                     .LEVELS(LEVELS)) u_addr (
    .va         (va_q),
    .root_frame (root_q),
    .next_frame (next_q),
    .leaf_sel   (st == ST_L2_REQ),
    .addr       (mem_req_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      va_q     <= '0;
      root_q   <= '0;
      next_q   <= '0;
      rights_q <= '0;
      paddr_q  <= '0;
      fault_q  <= 1'b0;
      flvl_q   <= LVL_TOP;
    end else if (accept) begin
      va_q     <= req_vaddr;
      root_q   <= req_base[PA_W-1:OFF_W];
      rights_q <= '1;
      paddr_q  <= '0;
      fault_q  <= 1'b0;
      flvl_q   <= LVL_TOP;
    end else if (top_take) begin
      if (pte_ok) begin
        next_q   <= pte_frame;
        rights_q <= rights_q & pte_rights;
      end else begin
        fault_q  <= 1'b1;
        flvl_q   <= LVL_TOP;
        rights_q <= '0;
      end
    end else if (leaf_take) begin
      if (pte_ok) begin
        paddr_q  <= {pte_frame, va_q[OFF_W-1:0]};
        rights_q <= rights_q & pte_rights;
      end else begin
        fault_q  <= 1'b1;
        flvl_q   <= LVL_LEAF;
        rights_q <= '0;
      end
    end
  end

  always_comb begin
    req_ready      = (st == ST_IDLE);
    mem_req_valid  = (st == ST_L1_REQ) || (st == ST_L2_REQ);
    done_valid     = (st == ST_DONE);
    done_paddr     = paddr_q;
    done_rights    = rights_q;
    done_fault     = fault_q;
    done_fault_lvl = flvl_q;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid && req_ready); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req_valid && !done_valid); // R2
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
    done_valid && done_fault |-> done_paddr == '0 && done_rights == '0); // R8
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
    done_valid && !done_fault |-> done_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]); // R6
endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [31:0] req_base  = '0;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        done_valid;
  logic [31:0] done_paddr;
  logic [2:0]  done_rights;
  logic        done_fault;
  logic        done_fault_lvl;

  always #10 clk = ~clk; // 50 MHz

  pt_walker dut_i (.*);

  // Memory model: 16 KB of words, fixed response latency, optional stall.
  logic [31:0] mem [0:4095];
  logic        pend = 1'b0;
  logic [3:0]  cnt = '0;
  logic [31:0] pa_q = '0;
  logic        stall = 1'b0;
  logic [3:0]  lat = 4'd0;
  int          rd_count = 0;
  logic [31:0] addr_log [4];
  logic        rsp_v = 1'b0;
  logic [31:0] rsp_d = '0;

  assign mem_req_ready = !pend && !stall;
  assign mem_rsp_valid = rsp_v;
  assign mem_rsp_data  = rsp_d;

  always @(posedge clk) begin
    if (rst) begin
      rsp_v <= 1'b0;
      pend  <= 1'b0;
    end else begin
      rsp_v <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        pend     <= 1'b1;
        cnt      <= lat;
        pa_q     <= mem_req_addr;
        addr_log[rd_count[1:0]] <= mem_req_addr;
        rd_count <= rd_count + 1;
      end else if (pend) begin
        if (cnt == 0) begin
          rsp_v <= 1'b1;
          rsp_d <= mem[pa_q[13:2]];
          pend  <= 1'b0;
        end else cnt <= cnt - 1;
      end
    end
  end

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  localparam logic [31:0] BASE = 32'h0000_1ABC; // low bits junk, R3

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // Result captured at the done strobe.
  logic [31:0] r_pa;
  logic [2:0]  r_rt;
  logic        r_flt, r_lvl;
  int          r_reads;
  logic [31:0] r_a0, r_a1;

  task automatic finish_walk(input int start);
    for (int i = 0; i < 200 && !done_valid; i++) @(negedge clk);
    chk(done_valid, "R10", "done strobe seen", {31'd0, done_valid}, 32'd1);
    r_pa    = done_paddr;
    r_rt    = done_rights;
    r_flt   = done_fault;
    r_lvl   = done_fault_lvl;
    r_reads = rd_count - start;
    r_a0    = addr_log[start[1:0]];
    r_a1    = addr_log[2'(start + 1)];
    @(negedge clk);
    chk(!done_valid && req_ready, "R10", "one-cycle strobe then ready",
        {30'd0, done_valid, req_ready}, 32'd1);
  endtask

  task automatic run_walk(input logic [31:0] va);
    int start;
    start = rd_count;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_base = BASE;
    @(negedge clk);
    req_valid = 1'b0;
    finish_walk(start);
  endtask

  // Vector table: va, expected paddr, rights, fault, fault level.
  localparam int NV = 8;
  localparam logic [31:0] T_VA [NV] = '{32'h0000_5123, 32'h0000_6FFF, 32'h0000_7010,
    32'h0040_9456, 32'h0040_AABC, 32'h0080_0123, 32'h0040_7000, 32'hFFC0_0000};
  localparam logic [31:0] T_PA [NV] = '{32'hABCD_E123, 32'h1234_5FFF, 32'h0,
    32'h5555_5456, 32'h7777_7ABC, 32'h0, 32'h0, 32'h0};
  localparam logic [2:0] T_RT [NV] = '{3'd7, 3'd3, 3'd0, 3'd0, 3'd1, 3'd0, 3'd0, 3'd0};
  localparam logic [NV-1:0] T_FLT = 8'b1110_0100; // bit i = vector i
  localparam logic [NV-1:0] T_LVL = 8'b0100_0100;

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    // Top-level table at 0x1000 (word 0x400).
    mem[12'h400] = 32'h0000_200F;  // -> 0x2000, rwx
    mem[12'h401] = 32'h0000_3FF3;  // -> 0x3000, read only, junk bits 11:4 (R11)
    mem[12'h402] = 32'h0000_2FFE;  // not valid
    // Leaf table at 0x2000 (word 0x800).
    mem[12'h805] = 32'hABCD_E00F;
    mem[12'h806] = 32'h1234_5007;
    // Leaf table at 0x3000 (word 0xC00).
    mem[12'hC09] = 32'h5555_5FFD;  // write+exec, junk bits (R11)
    mem[12'hC0A] = 32'h7777_700F;

    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req_valid && !done_valid, "R1", "state during reset",
        {29'd0, req_ready, mem_req_valid, done_valid}, 32'h4);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_req_valid && !done_valid, "R1", "state after reset",
        {29'd0, req_ready, mem_req_valid, done_valid}, 32'h4);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] e0, e1;
      e0 = {BASE[31:12], T_VA[v][31:22], 2'b00};
      run_walk(T_VA[v]);
      chk(r_flt == T_FLT[v], T_FLT[v] ? (T_LVL[v] ? "R9" : "R8") : "R6",
          "fault flag", {31'd0, r_flt}, {31'd0, T_FLT[v]});
      chk(r_pa == T_PA[v], T_FLT[v] ? "R8" : "R6", "paddr", r_pa, T_PA[v]);
      chk(r_rt == T_RT[v], "R7", "rights", {29'd0, r_rt}, {29'd0, T_RT[v]});
      chk(r_a0 == e0, "R3", "first read address", r_a0, e0);
      if (T_FLT[v] && !T_LVL[v]) begin
        chk(r_lvl == 1'b0, "R8", "fault level", {31'd0, r_lvl}, 32'd0);
        chk(r_reads == 1, "R8", "single read", r_reads, 32'd1);
      end else begin
        e1 = {mem[e0[13:2]][31:12], T_VA[v][21:12], 2'b00};
        chk(r_reads == 2, "R4", "two reads", r_reads, 32'd2);
        chk(r_a1 == e1, "R4", "second read address", r_a1, e1);
        if (T_FLT[v]) chk(r_lvl == 1'b1, "R9", "fault level", {31'd0, r_lvl}, 32'd1);
      end
    end

    // R5: stalled request holds valid and address.
    begin
      int start;
      logic [31:0] a_hold;
      start = rd_count;
      stall = 1'b1;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = 32'h0040_AABC; req_base = BASE;
      @(negedge clk);
      req_valid = 1'b0;
      a_hold = mem_req_addr;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(mem_req_valid && mem_req_addr == a_hold, "R5", "stalled request held",
            mem_req_addr, a_hold);
      end
      stall = 1'b0;
      lat = 4'd3;
      finish_walk(start);
      lat = 4'd0;
      chk(r_pa == 32'h7777_7ABC && r_rt == 3'd1, "R5", "result after stall",
          r_pa, 32'h7777_7ABC);
    end

    // R2: requests while busy are ignored.
    begin
      int start;
      start = rd_count;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = 32'h0000_6FFF; req_base = BASE;
      @(negedge clk);
      req_vaddr = 32'h0080_0123;
      for (int i = 0; i < 200 && !done_valid; i++) begin
        chk(!req_ready, "R2", "not ready while busy", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
      end
      req_valid = 1'b0;
      finish_walk(start);
      chk(r_pa == 32'h1234_5FFF && !r_flt, "R2", "busy request ignored",
          r_pa, 32'h1234_5FFF);
      chk(r_reads == 2, "R2", "no extra reads", r_reads, 32'd2);
      repeat (3) @(negedge clk);
      chk(req_ready && !mem_req_valid, "R2", "idle after busy request dropped",
          {30'd0, req_ready, mem_req_valid}, 32'h2);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule